// File: doc/BRIEF.md
# Banked Memory Address Translator

This block turns a 12-bit instruction address into a physical memory selection. It shows three bank registers to the rest of the chip: an erasable-bank register, a fixed-bank register and a combined register that carries both bank fields. A superbank bit from an I/O channel is also an input. The block reports which of four address regions the address falls in, the physical bank number and the word offset inside that bank. It also flags a fixed-bank selection that points at a bank that does not exist.

There is only one copy of each bank field. A write through any of the three register views updates the field it carries, so every view stays consistent from the next edge onward. A read returns the register image for the view that is selected. When a write happens in the same cycle, the read already shows the value being written. The memories themselves sit outside this block.

Bit numbering in this document is zero-based: index 0 is the least significant bit of a 15-bit register word.

Top module: `bank_xlat_top`

## Requirements
- R1: After a synchronous reset, both bank fields are zero, and a read of any register view returns 0.
- R2: A write with select code 0 (erasable view) loads the 3-bit erasable field from data bits [10:8]. A read of view 0 returns that field at [10:8] and zero in every other bit. View 2 then shows the same field at [2:0].
- R3: A write with select code 1 (fixed view) loads the 5-bit fixed field from data bits [14:10]. A read of view 1 returns it at [14:10] and zero elsewhere. View 2 then shows the same field at [14:10].
- R4: A write with select code 2 (combined view) loads the fixed field from bits [14:10] and the erasable field from bits [2:0] in one write. Bits [9:3] are ignored and read back as zero.
- R5: The read data reflects a write made in the same cycle. A write with select code 3 changes nothing, and a read with select code 3 returns 0.
- R6: Addresses 0x000 to 0x2FF give region code 0 (unswitched erasable), bank 0, and an offset equal to the address.
- R7: Addresses 0x300 to 0x3FF give region code 1 (switched erasable), the erasable field as the bank, and the address bits [7:0] as the offset.
- R8: Addresses 0x400 to 0x7FF give region code 2 (common fixed) and the address bits [9:0] as the offset. When the superbank bit is 0, the bank equals the fixed field.
- R9: When the superbank bit is 1, fixed-field values 24 to 31 map to physical banks 32 to 39. Values 0 to 23 are unchanged.
- R10: Addresses 0x800 to 0xFFF give region code 3 (fixed-fixed), bank 0, and the address bits [10:0] as the offset. The bank registers and the superbank bit have no effect on this result.
- R11: The invalid-bank flag is high only in region 2, and only when the physical bank is 36 or above.
- R12: Translation uses the bank fields as they stood after the last clock edge. A write changes the translation from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register view select for writes (0 erasable, 1 fixed, 2 combined, 3 none) |
| wr_data | input | 15 | Register write data |
| rd_sel | input | 2 | Register view select for reads |
| rd_data | output | 15 | Register image of the selected view |
| super_bit | input | 1 | Superbank bit from the I/O channel |
| addr | input | 12 | Instruction address to translate |
| region | output | 2 | Region code (0 unswitched erasable, 1 switched erasable, 2 common fixed, 3 fixed-fixed) |
| bank | output | 6 | Physical bank number |
| offset | output | 11 | Word offset inside the bank |
| bank_invalid | output | 1 | Selected fixed bank does not exist |

## Verification
The assertions check several things on every cycle. After each write the stored fields follow the written data, and the fields hold when there is no write. Unused read bits stay zero. The invalid flag appears only in the common fixed region. The fixed-fixed region always reports bank 0, and a remapped upper bank appears only while the superbank bit is set. Some behaviour can only be shown by the bench scenarios. These are the same-cycle read bypass and the one-cycle lag of translation behind a write. They also include the exact region boundaries over a sweep of all 4096 addresses, and the full remap table for every fixed-field value with the superbank bit clear and set.

// File: rtl/bank_xlat_pkg.sv
// Package: shared widths, region codes and register view selects for the
// banked address translator. Assumes 15-bit register words and a 12-bit
// instruction address.
package bank_xlat_pkg;
    localparam int ADDR_W   = 12;
    localparam int WORD_W   = 15;
    localparam int EFLD_W   = 3;
    localparam int FFLD_W   = 5;
    localparam int PBANK_W  = 6;
    localparam int OFS_W    = 11;
    localparam int SEL_W    = 2;

    typedef enum logic [1:0] {
        RG_UNSW = 2'd0,
        RG_SWER = 2'd1,
        RG_CFIX = 2'd2,
        RG_FFIX = 2'd3
    } region_e;

    localparam logic [SEL_W-1:0] SEL_ERASE = 2'd0;
    localparam logic [SEL_W-1:0] SEL_FIXED = 2'd1;
    localparam logic [SEL_W-1:0] SEL_BOTH  = 2'd2;
endpackage

// File: rtl/bank_regs.sv
// Module: bank_regs
// Holds the single copy of the erasable and fixed bank fields and presents
// three register views of them: erasable, fixed and combined. A write
// through any view updates the fields it carries. Reads are bypassed from
// the next-state values, so a read in the same cycle as a write shows the
// written value. Assumes a synchronous active-low reset.
module bank_regs
    import bank_xlat_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int EW     = EFLD_W,
    parameter int FW     = FFLD_W,
    parameter int E_LSB  = 8,
    parameter int F_LSB  = 10,
    parameter int BE_LSB = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [W-1:0]     rd_data,
    output logic [EW-1:0]    efld_q,
    output logic [FW-1:0]    ffld_q
);
    localparam logic [W-1:0] E_MASK  = W'(((1 << EW) - 1) << E_LSB);
    localparam logic [W-1:0] F_MASK  = W'(((1 << FW) - 1) << F_LSB);
    localparam logic [W-1:0] BE_MASK = W'(((1 << EW) - 1) << BE_LSB);

    logic [EW-1:0] e_nxt;
    logic [FW-1:0] f_nxt;
    logic          unused_wr_bits;

    // Bits of the write word that no view decodes.
    assign unused_wr_bits = ^(wr_data & ~(E_MASK | F_MASK | BE_MASK));

    // Next-state of the fields from the selected write view.
    always_comb begin
        e_nxt = efld_q;
        f_nxt = ffld_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_ERASE: e_nxt = wr_data[E_LSB +: EW];
                SEL_FIXED: f_nxt = wr_data[F_LSB +: FW];
                SEL_BOTH: begin
                    e_nxt = wr_data[BE_LSB +: EW];
                    f_nxt = wr_data[F_LSB +: FW];
                end
                default: ;
            endcase
        end
    end

    // Field storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            efld_q <= '0;
            ffld_q <= '0;
        end else begin
            efld_q <= e_nxt;
            ffld_q <= f_nxt;
        end
    end

    // Register image of the selected view, from the next-state fields.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_ERASE: rd_data[E_LSB +: EW] = e_nxt;
            SEL_FIXED: rd_data[F_LSB +: FW] = f_nxt;
            SEL_BOTH: begin
                rd_data[F_LSB +: FW]  = f_nxt;
                rd_data[BE_LSB +: EW] = e_nxt;
            end
            default: ;
        endcase
    end

    // R2
    erase_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ERASE) |=> (efld_q == $past(wr_data[E_LSB +: EW])));
    // R3
    fixed_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_FIXED) |=> (ffld_q == $past(wr_data[F_LSB +: FW])));
    // R4
    both_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_BOTH) |=>
            (efld_q == $past(wr_data[BE_LSB +: EW]) && ffld_q == $past(wr_data[F_LSB +: FW])));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel == 2'd3) |=> ($stable(efld_q) && $stable(ffld_q)));
    // R4
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~(E_MASK | F_MASK | BE_MASK)) == '0));
endmodule

// File: rtl/fixed_bank_map.sv
// Module: fixed_bank_map
// Maps the fixed-bank field to a physical bank. When the superbank bit is set,
// it moves the upper group of field values (top two bits all ones) to the bank
// group above. It flags banks at or above the populated count. SUPER_EN
// selects whether the remap is built at all.
module fixed_bank_map
    import bank_xlat_pkg::*;
#(
    parameter int FW        = FFLD_W,
    parameter int PW        = PBANK_W,
    parameter int NUM_BANKS = 36,
    parameter bit SUPER_EN  = 1'b1
) (
    input  logic [FW-1:0] ffld,
    input  logic          super_bit,
    output logic [PW-1:0] pbank,
    output logic          bad_bank
);
    localparam int LOW_W = FW - 2;

    generate
        if (SUPER_EN) begin : g_super
            logic upper_grp;
            // The upper group is remapped when the superbank bit is set.
            always_comb begin
                upper_grp = &ffld[FW-1:FW-2];
                if (super_bit && upper_grp)
                    pbank = PW'((1 << (PW - 1)) | ffld[LOW_W-1:0]);
                else
                    pbank = PW'(ffld);
            end
        end else begin : g_plain
            logic unused_super;
            assign unused_super = super_bit;
            assign pbank = PW'(ffld);
        end
    endgenerate

    // Bank beyond the populated range.
    assign bad_bank = (int'(pbank) >= NUM_BANKS);
endmodule

// File: rtl/addr_decode.sv
// Module: addr_decode
// Splits the address into four regions by fixed boundaries and forms the
// physical bank and the offset. It assumes the bank fields are already stable
// for the cycle.
module addr_decode
    import bank_xlat_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int EW = EFLD_W,
    parameter int PW = PBANK_W,
    parameter int OW = OFS_W
) (
    input  logic [AW-1:0] addr,
    input  logic [EW-1:0] efld,
    input  logic [PW-1:0] fix_bank,
    input  logic          fix_bad,
    output region_e       region,
    output logic [PW-1:0] bank,
    output logic [OW-1:0] offset,
    output logic          invalid
);
    localparam logic [AW-1:0] SWER_BASE = AW'(12'o1400);
    localparam logic [AW-1:0] CFIX_BASE = AW'(12'o2000);
    localparam logic [AW-1:0] FFIX_BASE = AW'(12'o4000);
    localparam int SWER_OW = 8;
    localparam int CFIX_OW = 10;

    // Region select and the bank/offset formation for each region.
    always_comb begin
        invalid = 1'b0;
        if (addr < SWER_BASE) begin
            region = RG_UNSW;
            bank   = '0;
            offset = OW'(addr);
        end else if (addr < CFIX_BASE) begin
            region = RG_SWER;
            bank   = PW'(efld);
            offset = OW'(addr[SWER_OW-1:0]);
        end else if (addr < FFIX_BASE) begin
            region  = RG_CFIX;
            bank    = fix_bank;
            offset  = OW'(addr[CFIX_OW-1:0]);
            invalid = fix_bad;
        end else begin
            region = RG_FFIX;
            bank   = '0;
            offset = addr[OW-1:0];
        end
    end
endmodule

// File: rtl/bank_xlat_top.sv
// Module: bank_xlat_top
// Banked memory address translator. It holds the bank registers and
// translates the address against the registered fields. Translation follows
// a register write one cycle later. Assumes a synchronous active-low reset.
module bank_xlat_top
    import bank_xlat_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [14:0]  wr_data,
    input  logic [1:0]   rd_sel,
    output logic [14:0]  rd_data,
    input  logic         super_bit,
    input  logic [11:0]  addr,
    output logic [1:0]   region,
    output logic [5:0]   bank,
    output logic [10:0]  offset,
    output logic         bank_invalid
);
    logic [EFLD_W-1:0]  efld;
    logic [FFLD_W-1:0]  ffld;
    logic [PBANK_W-1:0] fix_bank;
    logic               fix_bad;
    region_e            region_d;

    bank_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .efld_q  (efld),
        .ffld_q  (ffld)
    );

    fixed_bank_map u_map (
        .ffld      (ffld),
        .super_bit (super_bit),
        .pbank     (fix_bank),
        .bad_bank  (fix_bad)
    );

    addr_decode u_dec (
        .addr     (addr),
        .efld     (efld),
        .fix_bank (fix_bank),
        .fix_bad  (fix_bad),
        .region   (region_d),
        .bank     (bank),
        .offset   (offset),
        .invalid  (bank_invalid)
    );

    // Region code to the port.
    assign region = region_d;

    // R11
    invalid_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_invalid |-> (region == RG_CFIX));
    // R10
    ffix_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_FFIX) |-> (bank == '0 && offset == addr[10:0]));
    // R9
    remap_needs_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_CFIX && bank[5]) |-> super_bit);
    // R6
    unsw_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_UNSW) |-> (bank == '0 && offset == 11'(addr)));
endmodule

// File: tb/tb_bank_xlat_top.sv
module tb_bank_xlat_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [14:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [14:0] rd_data;
    logic        super_bit = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  region;
    logic [5:0]  bank;
    logic [10:0] offset;
    logic        bank_invalid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int em = 0;
    int fm = 0;

    bank_xlat_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .super_bit(super_bit), .addr(addr), .region(region), .bank(bank),
        .offset(offset), .bank_invalid(bank_invalid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_read(input int sel);
        case (sel)
            0: return em << 8;
            1: return fm << 10;
            2: return (fm << 10) | em;
            default: return 0;
        endcase
    endfunction

    task automatic chk_reads(input string tag);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            chk(tag, int'(rd_data), exp_read(s));
        end
    endtask

    task automatic chk_xlat(input string tag);
        int a, r, b, o, inv;
        a = int'(addr);
        inv = 0;
        if (a < 'o1400) begin r = 0; b = 0; o = a; end
        else if (a < 'o2000) begin r = 1; b = em; o = a & 'hFF; end
        else if (a < 'o4000) begin
            r = 2; o = a & 'h3FF;
            b = (super_bit && fm >= 24) ? fm + 8 : fm;
            inv = (b >= 36) ? 1 : 0;
        end else begin r = 3; b = 0; o = a & 'h7FF; end
        #1;
        chk({tag, " region"}, int'(region), r);
        chk({tag, " bank"}, int'(bank), b);
        chk({tag, " offset"}, int'(offset), o);
        chk({tag, " invalid"}, int'(bank_invalid), inv);
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = 2'(sel);
        wr_data = 15'(data);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        case (sel)
            0: em = (data >> 8) & 7;
            1: fm = (data >> 10) & 31;
            2: begin fm = (data >> 10) & 31; em = data & 7; end
            default: ;
        endcase
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_reads("R1 reset read");
        addr = 12'h500;
        chk_xlat("R1 reset xlat");

        // R2 erasable view, junk in other bits
        for (int e = 0; e < 8; e++) begin
            wr(0, ('h7FFF & ~(7 << 8)) | (e << 8));
            chk_reads("R2 erasable view");
        end
        // R3 fixed view, junk in other bits
        for (int f = 0; f < 32; f++) begin
            wr(1, ('h7FFF & ~(31 << 10)) | (f << 10));
            chk_reads("R3 fixed view");
        end
        // R4 combined view, middle bits ignored
        for (int v = 0; v < 8; v++) begin
            wr(2, ((v * 5 + 3) % 32 << 10) | ('h3F8) | v);
            chk_reads("R4 combined view");
        end

        // R5 same-cycle bypass, then R12 translation lag
        @(negedge clk);
        addr = 12'h400;
        super_bit = 1'b0;
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 15'(9 << 10);
        rd_sel = 2'd2;
        #1;
        chk("R5 bypass read", int'(rd_data), (9 << 10) | em);
        chk("R12 old bank during write", int'(bank), fm);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        fm = 9;
        chk("R12 new bank after edge", int'(bank), 9);
        // R5 select code 3 write is ignored
        wr(3, 'h7FFF);
        chk_reads("R5 code3 ignored");

        // R8 R9 R11 remap table at both ends of the common fixed region
        for (int f = 0; f < 32; f++) begin
            wr(1, f << 10);
            for (int s = 0; s < 2; s++) begin
                super_bit = s[0];
                addr = 12'h400; chk_xlat("R9 remap low");
                addr = 12'h7FF; chk_xlat("R8 remap high");
            end
        end

        // R6 R7 R8 R10 R11 full address sweeps for several settings
        for (int k = 0; k < 4; k++) begin
            wr(2, ((k == 0 ? 0 : (k == 1 ? 23 : (k == 2 ? 28 : 31))) << 10) | (k * 2 + 1));
            for (int s = 0; s < 2; s++) begin
                super_bit = s[0];
                for (int a = 0; a < 4096; a++) begin
                    addr = 12'(a);
                    chk_xlat("R6 R7 R10 sweep");
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule